// File: doc/BRIEF.md
# Character Pattern Bank Translator

This block sits between the picture-processing bus and a large character ROM. It takes the 8K pattern-table address range (picture address bits 12..0) and turns its top three bits into ROM address bits 10 and up. The mapping is set by a group of bank-number registers and a few control registers that the processor writes. The same block also produces the A10 line of the internal nametable RAM, chosen by a mirroring setting.

Eight bank entries are each 16 bits wide. The low byte sits in one register page and the high byte in another, at the same index. A two-bit size setting divides the pattern space into one 8K window, two 4K halves, four 2K quarters or eight 1K slices. A bank number always counts in units of the current window size. An outer 256K window select can confine the whole result to one 256K region of the ROM, or a bypass bit can hand the full ROM to the bank entries. A repeat bit makes the 1K and 2K layouts fold the lower 4K, so that the first half of it shows twice.

Top module: `chrbank_mapper`

## Requirements
- R1: After reset the size setting is 8K, every bank entry and the outer select are zero, the outer window is active, and mirroring is vertical. The ROM output then equals picture address bits 12..10, and the nametable A10 equals picture bit 10.
- R2: Bank entry k (k = 0..7) is 16 bits. Its low byte is written at 0x9000+k and its high byte at 0xA000+k. The value is an absolute bank number in units of the active window size.
- R3: With size code 0 (8K), the output in 1K units is entry0*8 + picture bits 12..10.
- R4: With size code 1 (4K), picture bit 12 picks entry 0 or 4, and the output is entry*4 + picture bits 11..10.
- R5: With size code 2 (2K), picture bits 12..11 pick entry 0, 2, 4 or 6, and the output is entry*2 + picture bit 10.
- R6: With size code 3 (1K), picture bits 12..10 pick entries 0..7, and the output is that entry.
- R7: With control register 0xD003 bit 5 clear, output bits 7..0 (1K units) come from the computed value, and the bits above come from 0xD003 bits 4..0, truncated to the output width.
- R8: With 0xD003 bit 5 set, the outer select is ignored and the computed value, truncated to the output width, is driven directly.
- R9: With 0xD003 bit 7 set in size codes 2 and 3 only, picture bit 11 is treated as 0 whenever picture bit 12 is 0. In size codes 0 and 1 the bit has no effect.
- R10: 0xD001 bits 1..0 select the nametable A10: 0 gives picture bit 10, 1 gives picture bit 11, 2 gives constant 0, 3 gives constant 1.
- R11: Registers decode on write address bits 15..12 and 2..0. The size code is 0xD000 bits 4..3. The control page 0xD000-0xD003 repeats at 0xD004-0xD007. Writes to any other page leave both outputs unchanged.
- R12: A register write takes effect at the clock edge that samples it. The translation from picture address to outputs is combinational within the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Processor register write strobe |
| wrAddr | input | 16 | Processor write address |
| wrData | input | 8 | Processor write data |
| ppuAddr | input | 13 | Picture bus address bits 12..0 |
| chrHi | output | ROM_AW-10 (12) | Character ROM address bits 10 and up |
| ciramA10 | output | 1 | Nametable RAM A10 |

## Verification
Both outputs are combinational functions of the picture address and the stored registers. A change in the picture address therefore shows up in the same cycle, and a register write shows up one edge after the cycle that carries it. The bench drives each write for one cycle starting on a falling edge. It then sets the picture address and samples shortly after the next falling edge, so every sample falls between clock edges. One directed test samples while a write is still pending, to confirm the old mapping holds until the edge. It samples again one edge later to confirm the new mapping.

// File: rtl/chrbank_pkg.sv
package chrbank_pkg;

  typedef enum logic [1:0] {
    SIZE_8K = 2'd0,
    SIZE_4K = 2'd1,
    SIZE_2K = 2'd2,
    SIZE_1K = 2'd3
  } sizeMode_e;

  typedef enum logic [1:0] {
    MIR_VERT = 2'd0,
    MIR_HORZ = 2'd1,
    MIR_ONE0 = 2'd2,
    MIR_ONE1 = 2'd3
  } mirror_e;

  // one-cycle write strobes from the decoder to the datapath
  typedef struct packed {
    logic       loEn;
    logic       hiEn;
    logic       sizeEn;
    logic       mirEn;
    logic       outerEn;
    logic [2:0] idx;
    logic [7:0] data;
  } regStrobe_t;

endpackage

// File: rtl/chrbank_ctrl.sv
module chrbank_ctrl
  import chrbank_pkg::*;
#(
  parameter logic [3:0] PAGE_LO  = 4'h9,
  parameter logic [3:0] PAGE_HI  = 4'hA,
  parameter logic [3:0] PAGE_CTL = 4'hD
) (
  input  logic        wrEn,
  input  logic [15:0] wrAddr,
  input  logic [7:0]  wrData,
  output regStrobe_t  strb
);

  logic [3:0] page;
  logic       unusedAddr;

  assign page       = wrAddr[15:12];
  assign unusedAddr = ^wrAddr[11:3];

  always_comb begin
    strb         = '0;
    strb.idx     = wrAddr[2:0];
    strb.data    = wrData;
    strb.loEn    = wrEn && (page == PAGE_LO);
    strb.hiEn    = wrEn && (page == PAGE_HI);
    if (wrEn && (page == PAGE_CTL)) begin
      // control page repeats every four addresses
      unique case (wrAddr[1:0])
        2'd0:    strb.sizeEn  = 1'b1;
        2'd1:    strb.mirEn   = 1'b1;
        2'd3:    strb.outerEn = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/chrbank_dp.sv
module chrbank_dp
  import chrbank_pkg::*;
#(
  parameter int BANK_W  = 16,
  parameter int ROM_AW  = 22,
  parameter int OUTER_W = 5,
  parameter int WIN_W   = 8,
  parameter int ENTRIES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  regStrobe_t           strb,
  input  logic [2:0]           slot,
  input  logic                 ppuA11,
  input  logic                 ppuA10,
  output logic [ROM_AW-11:0]   chrHi,
  output logic                 ciramA10
);

  localparam int OUT_W  = ROM_AW - 10;
  localparam int UNIT_W = BANK_W + 3;
  localparam int HALF_W = BANK_W - 8;

  logic [7:0]        bankLo [ENTRIES];
  logic [HALF_W-1:0] bankHi [ENTRIES];
  sizeMode_e         sizeMode;
  mirror_e           mirror;
  logic [OUTER_W-1:0] outerSel;
  logic              bypass;
  logic              repeatEn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sizeMode <= SIZE_8K;
      mirror   <= MIR_VERT;
      outerSel <= '0;
      bypass   <= 1'b0;
      repeatEn <= 1'b0;
    end else begin
      if (strb.sizeEn) sizeMode <= sizeMode_e'(strb.data[4:3]);
      if (strb.mirEn)  mirror   <= mirror_e'(strb.data[1:0]);
      if (strb.outerEn) begin
        repeatEn <= strb.data[7];
        bypass   <= strb.data[5];
        outerSel <= strb.data[OUTER_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bankLo[g] <= '0;
        bankHi[g] <= '0;
      end else begin
        if (strb.loEn && strb.idx == 3'(g)) bankLo[g] <= strb.data;
        if (strb.hiEn && strb.idx == 3'(g)) bankHi[g] <= strb.data[HALF_W-1:0];
      end
    end
  end

  logic [2:0]        effSlot;
  logic [2:0]        entryIdx;
  logic [BANK_W-1:0] bankNum;
  logic [UNIT_W-1:0] unitAddr;
  logic [OUTER_W+WIN_W-1:0] windowed;

  always_comb begin
    effSlot = slot;
    if (repeatEn && (sizeMode == SIZE_2K || sizeMode == SIZE_1K) && !slot[2])
      effSlot[1] = 1'b0;

    unique case (sizeMode)
      SIZE_8K: entryIdx = 3'd0;
      SIZE_4K: entryIdx = {effSlot[2], 2'b00};
      SIZE_2K: entryIdx = {effSlot[2:1], 1'b0};
      default: entryIdx = effSlot;
    endcase

    bankNum = {bankHi[entryIdx], bankLo[entryIdx]};

    unique case (sizeMode)
      SIZE_8K: unitAddr = {bankNum, effSlot};
      SIZE_4K: unitAddr = {1'b0, bankNum, effSlot[1:0]};
      SIZE_2K: unitAddr = {2'b00, bankNum, effSlot[0]};
      default: unitAddr = {3'b000, bankNum};
    endcase

    windowed = {outerSel, unitAddr[WIN_W-1:0]};
    chrHi    = bypass ? OUT_W'(unitAddr) : OUT_W'(windowed);

    unique case (mirror)
      MIR_VERT: ciramA10 = ppuA10;
      MIR_HORZ: ciramA10 = ppuA11;
      MIR_ONE0: ciramA10 = 1'b0;
      default:  ciramA10 = 1'b1;
    endcase
  end

endmodule

// File: rtl/chrbank_mapper.sv
module chrbank_mapper
  import chrbank_pkg::*;
#(
  parameter int BANK_W  = 16,
  parameter int ROM_AW  = 22,
  parameter int OUTER_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [15:0]         wrAddr,
  input  logic [7:0]          wrData,
  input  logic [12:0]         ppuAddr,
  output logic [ROM_AW-11:0]  chrHi,
  output logic                ciramA10
);

  regStrobe_t strb;
  logic       unusedPpu;

  assign unusedPpu = ^ppuAddr[9:0];

  chrbank_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strb   (strb)
  );

  chrbank_dp #(
    .BANK_W  (BANK_W),
    .ROM_AW  (ROM_AW),
    .OUTER_W (OUTER_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .slot     (ppuAddr[12:10]),
    .ppuA11   (ppuAddr[11]),
    .ppuA10   (ppuAddr[10]),
    .chrHi    (chrHi),
    .ciramA10 (ciramA10)
  );

endmodule

// File: rtl/chrbank_chk.sv
module chrbank_chk #(
  parameter int ROM_AW = 22
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wrEn,
  input logic [15:0]        wrAddr,
  input logic [7:0]         wrData,
  input logic [12:0]        ppuAddr,
  input logic [ROM_AW-11:0] chrHi,
  input logic               ciramA10
);

  localparam int OUT_W = ROM_AW - 10;

  logic ctlMirWr;
  logic touchWr;
  assign ctlMirWr = wrEn && wrAddr[15:12] == 4'hD && wrAddr[1:0] == 2'd1;
  assign touchWr  = wrEn && (wrAddr[15:12] == 4'h9 || wrAddr[15:12] == 4'hA ||
                             wrAddr[15:12] == 4'hD);

  // first cycle out of reset shows the identity mapping
  p_reset_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (chrHi == OUT_W'(ppuAddr[12:10])) && (ciramA10 == ppuAddr[10]));

  p_single0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlMirWr && wrData[1:0] == 2'd2) |=> !ciramA10);

  p_single1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlMirWr && wrData[1:0] == 2'd3) |=> ciramA10);

  // no write to a mapping page: outputs move only with the picture address
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !touchWr |=> (!$stable(ppuAddr) || ($stable(chrHi) && $stable(ciramA10))));

endmodule

bind chrbank_mapper chrbank_chk #(.ROM_AW(ROM_AW)) u_chk (.*);

// File: tb/chrbank_mapper_tb.sv
module chrbank_mapper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROM_AW     = 22;
  localparam int OUT_W      = ROM_AW - 10;
  localparam int NVEC       = 22;

  // {req, write, addr, data, ppu, expChr, expCiram}
  localparam logic [54:0] VEC [NVEC] = '{
    {4'd3,  1'b1, 16'h9000, 8'h05, 13'h1400, 12'h02D, 1'b1}, // R3
    {4'd7,  1'b1, 16'hA000, 8'h01, 13'h0000, 12'h028, 1'b0}, // R7
    {4'd8,  1'b1, 16'hD003, 8'h20, 13'h0000, 12'h828, 1'b0}, // R8
    {4'd4,  1'b1, 16'hD000, 8'h08, 13'h1C00, 12'h003, 1'b1}, // R4
    {4'd4,  1'b1, 16'h9004, 8'h10, 13'h1800, 12'h042, 1'b0}, // R4
    {4'd2,  1'b0, 16'h0000, 8'h00, 13'h0400, 12'h415, 1'b1}, // R2
    {4'd5,  1'b1, 16'hD000, 8'h10, 13'h0800, 12'h000, 1'b0}, // R5
    {4'd5,  1'b1, 16'h9002, 8'h33, 13'h0C00, 12'h067, 1'b1}, // R5
    {4'd9,  1'b1, 16'hD003, 8'hA0, 13'h0C00, 12'h20B, 1'b1}, // R9
    {4'd9,  1'b1, 16'hD000, 8'h18, 13'h0800, 12'h105, 1'b0}, // R9
    {4'd6,  1'b1, 16'h9001, 8'h07, 13'h0C00, 12'h007, 1'b1}, // R6
    {4'd6,  1'b1, 16'h9005, 8'h09, 13'h1400, 12'h009, 1'b1}, // R6
    {4'd6,  1'b1, 16'hD003, 8'h20, 13'h0800, 12'h033, 1'b0}, // R6
    {4'd7,  1'b1, 16'hD003, 8'h02, 13'h0000, 12'h205, 1'b0}, // R7
    {4'd10, 1'b1, 16'hD001, 8'h01, 13'h0800, 12'h233, 1'b1}, // R10
    {4'd11, 1'b1, 16'hD005, 8'h02, 13'h0C00, 12'h200, 1'b0}, // R11
    {4'd10, 1'b1, 16'hD001, 8'h03, 13'h0000, 12'h205, 1'b1}, // R10
    {4'd11, 1'b1, 16'hE000, 8'hFF, 13'h0000, 12'h205, 1'b1}, // R11
    {4'd11, 1'b1, 16'h8001, 8'h55, 13'h0400, 12'h207, 1'b1}, // R11
    {4'd9,  1'b1, 16'hD003, 8'hA0, 13'h0C00, 12'h007, 1'b1}, // R9
    {4'd9,  1'b1, 16'hD000, 8'h08, 13'h0C00, 12'h417, 1'b1}, // R9
    {4'd9,  1'b1, 16'hD000, 8'h00, 13'h0800, 12'h82A, 1'b1}  // R9
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wrEn = 1'b0;
  logic [15:0]      wrAddr = '0;
  logic [7:0]       wrData = '0;
  logic [12:0]      ppuAddr = '0;
  logic [OUT_W-1:0] chrHi;
  logic             ciramA10;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chrbank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ppuAddr(ppuAddr), .chrHi(chrHi), .ciramA10(ciramA10)
  );

  task automatic checkOut(input int req, input logic [OUT_W-1:0] expChr,
                          input logic expCir);
    checks++;
    if (chrHi !== expChr) begin
      errors++;
      $display("FAIL R%0d chrHi actual %h expected %h (ppu %h)", req, chrHi, expChr, ppuAddr);
    end
    checks++;
    if (ciramA10 !== expCir) begin
      errors++;
      $display("FAIL R%0d ciramA10 actual %b expected %b (ppu %h)", req, ciramA10, expCir, ppuAddr);
    end
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, identity mapping and vertical mirroring
    ppuAddr = 13'h1C00; #1 checkOut(1, 12'h007, 1'b1);
    ppuAddr = 13'h0800; #1 checkOut(1, 12'h002, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][50]) regWrite(VEC[i][49:34], VEC[i][33:26]);
      else @(negedge clk);
      ppuAddr = VEC[i][25:13];
      #1 checkOut(int'(VEC[i][54:51]), VEC[i][12:1], VEC[i][0]);
    end

    // R12: pending write must not show before the edge, must show after
    @(negedge clk);
    ppuAddr = 13'h0000;
    wrEn = 1'b1; wrAddr = 16'hA000; wrData = 8'h01;
    #1 checkOut(12, 12'h828, 1'b1);
    wrData = 8'h01; wrAddr = 16'h9000;
    @(negedge clk);
    wrEn = 1'b0;
    #1 checkOut(12, 12'h808, 1'b1);

    // R1: reset in mid-run restores the initial mapping
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ppuAddr = 13'h1C00;
    #1 checkOut(1, 12'h007, 1'b1);
    ppuAddr = 13'h0800;
    #1 checkOut(1, 12'h002, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule